// File: doc/BRIEF.md
# Host Bus Address Decoder and Command Splitter

This block sits between an 8-bit processor with a 16-bit address and the memories and peripheral ports around it. The processor shares its low address byte with the data bus. When the address strobe is high, the block captures that byte and keeps it after the strobe falls, so the shared pins can then carry data. The captured low byte is joined with the live high byte to form the full 16-bit address.

The block takes the processor's space select (low for memory, high for I/O) and its two active-low strobes. From them it makes four separate active-high commands. It decodes the address into one chip select per configured memory region and per peripheral port. Memory regions are matched on all 16 bits. Ports are matched on the captured low byte only.

On a read that hits a decoded device, the block turns on a bus-drive enable toward the processor and forwards that device's read byte. In every other case the enable is low and the output byte is zero. This models a tri-state driver as an enable plus a data value. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `hostbus_decoder`

## Requirements
- R1: While reset is high, and on the first edge after it, every command, every chip select, the error flag, the bus enable, the output byte and the address output are zero.
- R2: The low-byte register follows the shared bus while the address strobe is high and holds its value while the strobe is low. The address output is {high byte, low byte}, registered one cycle after the inputs it reflects.
- R3: With the space select low (memory), a low read strobe and a high write strobe give a memory read. A low write strobe and a high read strobe give a memory write.
- R4: With the space select high (I/O), the same strobe patterns give an I/O read or an I/O write, and no memory command.
- R5: When both strobes are low together, all four commands stay low and the error flag is high. The flag clears on the first cycle in which the two strobes are not both low.
- R6: Memory selects are active only while the space select is low. The default regions are:
  - select bit 0: 0000h–3FFFh
  - select bit 1: 8000h–87FFh
  - select bit 2: F000h–FFFFh
  Each region is a power-of-two span aligned on its size.
- R7: Port selects are active only while the space select is high. They depend only on the captured low byte; the high byte has no effect. The default ports are:
  - select bit 0: 20h–23h
  - select bit 1: 80h–8Fh
- R8: At most one of all the chip selects is active in any cycle, and at most one command. An address in a gap between regions activates no select.
- R9: The bus enable is high only for a read command whose address hits a select. The output byte is then the read byte of the selected device and is zero otherwise. Device read bytes are packed in this order: memory regions 0..2 at bits 8i+7:8i, then ports 0..1 at the next byte positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_i | input | 1 | Address strobe, low byte captured while high |
| ad_i | input | 8 | Shared low-address/data bus from the processor |
| addr_hi_i | input | 8 | High address byte |
| io_sel_i | input | 1 | Space select: 0 memory, 1 I/O |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| dev_rdata_i | input | 40 | Packed read bytes of all devices |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Memory write command |
| io_rd_o | output | 1 | I/O read command |
| io_wr_o | output | 1 | I/O write command |
| strobe_err_o | output | 1 | Both strobes low together |
| addr_o | output | 16 | Reassembled full address |
| mem_cs_o | output | 3 | Memory region selects |
| port_cs_o | output | 2 | Port selects |
| bus_oe_o | output | 1 | Drive enable toward the processor |
| bus_dout_o | output | 8 | Byte driven toward the processor |

## Verification
The hardest case to reach is a transaction whose low address byte was captured several cycles earlier. By then the shared pins carry something else, so the decoded address mixes an old low byte with a new high byte. The stimulus reaches this by raising the strobe for one step and then changing the bus and the high byte with the strobe low. It also issues port reads with unrelated high bytes and drives both strobes low together. Boundary addresses on each side of every region and port are driven, and a stepped sweep through the whole space checks that no two selects ever overlap.

// File: rtl/hostbus_pkg.sv
`timescale 1ns/1ps
package hostbus_pkg;
  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } bus_cmd_t;

  localparam bus_cmd_t CMD_IDLE = '0;
endpackage

// File: rtl/hb_lo_latch.sv
`timescale 1ns/1ps
module hb_lo_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ale_i,
  input  logic [W-1:0] ad_i,
  output logic [W-1:0] lo_live_o
);
  logic [W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst)        lo_q <= '0;
    else if (ale_i) lo_q <= ad_i;
  end

  // transparent while the strobe is high, held value otherwise
  always_comb lo_live_o = ale_i ? ad_i : lo_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ale_i) |=> $stable(lo_q)); // R2
  AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!rst && ale_i) |=> (lo_q == $past(ad_i))); // R2
endmodule

// File: rtl/hb_cmd_gen.sv
`timescale 1ns/1ps
module hb_cmd_gen
  import hostbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     io_sel_i,
  input  logic     rd_n_i,
  input  logic     wr_n_i,
  output bus_cmd_t cmd_d_o,
  output bus_cmd_t cmd_q_o,
  output logic     err_q_o
);
  logic rd_req, wr_req, clash;

  always_comb begin
    rd_req  = ~rd_n_i;
    wr_req  = ~wr_n_i;
    clash   = rd_req & wr_req;
    cmd_d_o = CMD_IDLE;
    if (!clash) begin
      cmd_d_o.mem_rd = rd_req & ~io_sel_i;
      cmd_d_o.mem_wr = wr_req & ~io_sel_i;
      cmd_d_o.io_rd  = rd_req &  io_sel_i;
      cmd_d_o.io_wr  = wr_req &  io_sel_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q_o <= CMD_IDLE;
      err_q_o <= 1'b0;
    end else begin
      cmd_q_o <= cmd_d_o;
      err_q_o <= clash;
    end
  end

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err_q_o |-> (cmd_q_o == CMD_IDLE)); // R5
  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_q_o)); // R8
  AST_MEMRD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!rst && !io_sel_i && !rd_n_i && wr_n_i) |=> cmd_q_o.mem_rd); // R3
  AST_IOWR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!rst && io_sel_i && rd_n_i && !wr_n_i) |=> cmd_q_o.io_wr); // R4
endmodule

// File: rtl/hb_region_decode.sv
`timescale 1ns/1ps
module hb_region_decode #(
  parameter int ADDR_W = 16,
  parameter int PORT_W = 8,
  parameter int MEM_N  = 3,
  parameter int PORT_N = 2,
  parameter int SPAN_W = 5,
  parameter logic [MEM_N*ADDR_W-1:0]  MEM_BASE      = '0,
  parameter logic [MEM_N*SPAN_W-1:0]  MEM_SPAN_LOG  = '0,
  parameter logic [PORT_N*PORT_W-1:0] PORT_BASE     = '0,
  parameter logic [PORT_N*SPAN_W-1:0] PORT_SPAN_LOG = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_sel_i,
  output logic [MEM_N-1:0]  mem_sel_d_o,
  output logic [PORT_N-1:0] port_sel_d_o,
  output logic [MEM_N-1:0]  mem_cs_q_o,
  output logic [PORT_N-1:0] port_cs_q_o
);
  logic [PORT_W-1:0] port_addr;
  assign port_addr = addr_i[PORT_W-1:0];

  for (genvar g = 0; g < MEM_N; g++) begin : g_mem
    localparam logic [ADDR_W-1:0] BASE = MEM_BASE[g*ADDR_W +: ADDR_W];
    localparam int LG = int'(MEM_SPAN_LOG[g*SPAN_W +: SPAN_W]);
    assign mem_sel_d_o[g] = ~io_sel_i && ((addr_i >> LG) == (BASE >> LG));
  end

  for (genvar g = 0; g < PORT_N; g++) begin : g_port
    localparam logic [PORT_W-1:0] BASE = PORT_BASE[g*PORT_W +: PORT_W];
    localparam int LG = int'(PORT_SPAN_LOG[g*SPAN_W +: SPAN_W]);
    assign port_sel_d_o[g] = io_sel_i && ((port_addr >> LG) == (BASE >> LG));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs_q_o  <= '0;
      port_cs_q_o <= '0;
    end else begin
      mem_cs_q_o  <= mem_sel_d_o;
      port_cs_q_o <= port_sel_d_o;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({port_cs_q_o, mem_cs_q_o})); // R8
  AST_MEM_CS_SPACE: assert property (@(posedge clk) disable iff (rst)
    (!rst && io_sel_i) |=> (mem_cs_q_o == '0)); // R6
  AST_PORT_CS_SPACE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !io_sel_i) |=> (port_cs_q_o == '0)); // R7
endmodule

// File: rtl/hb_data_steer.sv
`timescale 1ns/1ps
module hb_data_steer #(
  parameter int DATA_W = 8,
  parameter int NDEV   = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_d_i,
  input  logic [NDEV-1:0]        sel_d_i,
  input  logic [NDEV*DATA_W-1:0] rdata_i,
  output logic                   oe_q_o,
  output logic [DATA_W-1:0]      dout_q_o
);
  logic [DATA_W-1:0] mux;
  logic              oe_d;

  always_comb begin
    mux = '0;
    for (int i = 0; i < NDEV; i++)
      if (sel_d_i[i]) mux = mux | rdata_i[i*DATA_W +: DATA_W];
    oe_d = rd_d_i & (|sel_d_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q_o   <= 1'b0;
      dout_q_o <= '0;
    end else begin
      oe_q_o   <= oe_d;
      dout_q_o <= oe_d ? mux : '0;
    end
  end

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !oe_q_o |-> (dout_q_o == '0)); // R9
endmodule

// File: rtl/hostbus_decoder.sv
`timescale 1ns/1ps
module hostbus_decoder
  import hostbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MEM_N  = 3,
  parameter int PORT_N = 2,
  parameter int SPAN_W = $clog2(ADDR_W + 1),
  parameter logic [MEM_N*ADDR_W-1:0]  MEM_BASE      = {16'hF000, 16'h8000, 16'h0000},
  parameter logic [MEM_N*SPAN_W-1:0]  MEM_SPAN_LOG  = {5'd12, 5'd11, 5'd14},
  parameter logic [PORT_N*DATA_W-1:0] PORT_BASE     = {8'h80, 8'h20},
  parameter logic [PORT_N*SPAN_W-1:0] PORT_SPAN_LOG = {5'd4, 5'd2}
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                ale_i,
  input  logic [DATA_W-1:0]                   ad_i,
  input  logic [ADDR_W-DATA_W-1:0]            addr_hi_i,
  input  logic                                io_sel_i,
  input  logic                                rd_n_i,
  input  logic                                wr_n_i,
  input  logic [(MEM_N+PORT_N)*DATA_W-1:0]    dev_rdata_i,
  output logic                                mem_rd_o,
  output logic                                mem_wr_o,
  output logic                                io_rd_o,
  output logic                                io_wr_o,
  output logic                                strobe_err_o,
  output logic [ADDR_W-1:0]                   addr_o,
  output logic [MEM_N-1:0]                    mem_cs_o,
  output logic [PORT_N-1:0]                   port_cs_o,
  output logic                                bus_oe_o,
  output logic [DATA_W-1:0]                   bus_dout_o
);
  localparam int NDEV = MEM_N + PORT_N;

  logic [DATA_W-1:0] lo_live;
  logic [ADDR_W-1:0] addr_live;
  logic [ADDR_W-1:0] addr_q;
  bus_cmd_t          cmd_d, cmd_q;
  logic [MEM_N-1:0]  mem_sel_d;
  logic [PORT_N-1:0] port_sel_d;

  hb_lo_latch #(.W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .ale_i(ale_i), .ad_i(ad_i), .lo_live_o(lo_live)
  );

  assign addr_live = {addr_hi_i, lo_live};

  hb_cmd_gen u_cmd (
    .clk(clk), .rst(rst), .io_sel_i(io_sel_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .cmd_d_o(cmd_d), .cmd_q_o(cmd_q), .err_q_o(strobe_err_o)
  );

  hb_region_decode #(
    .ADDR_W(ADDR_W), .PORT_W(DATA_W), .MEM_N(MEM_N), .PORT_N(PORT_N), .SPAN_W(SPAN_W),
    .MEM_BASE(MEM_BASE), .MEM_SPAN_LOG(MEM_SPAN_LOG),
    .PORT_BASE(PORT_BASE), .PORT_SPAN_LOG(PORT_SPAN_LOG)
  ) u_dec (
    .clk(clk), .rst(rst), .addr_i(addr_live), .io_sel_i(io_sel_i),
    .mem_sel_d_o(mem_sel_d), .port_sel_d_o(port_sel_d),
    .mem_cs_q_o(mem_cs_o), .port_cs_q_o(port_cs_o)
  );

  hb_data_steer #(.DATA_W(DATA_W), .NDEV(NDEV)) u_steer (
    .clk(clk), .rst(rst), .rd_d_i(cmd_d.mem_rd | cmd_d.io_rd),
    .sel_d_i({port_sel_d, mem_sel_d}), .rdata_i(dev_rdata_i),
    .oe_q_o(bus_oe_o), .dout_q_o(bus_dout_o)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_live;
  end

  assign addr_o   = addr_q;
  assign mem_rd_o = cmd_q.mem_rd;
  assign mem_wr_o = cmd_q.mem_wr;
  assign io_rd_o  = cmd_q.io_rd;
  assign io_wr_o  = cmd_q.io_wr;

  AST_ADDR_HI: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (addr_o[ADDR_W-1:DATA_W] == $past(addr_hi_i))); // R2
  AST_OE_QUAL: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> ((mem_rd_o | io_rd_o) && (|{port_cs_o, mem_cs_o}))); // R9
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_o | io_wr_o) |-> !bus_oe_o); // R9
endmodule

// File: tb/hostbus_decoder_test.sv
`timescale 1ns/1ps
module hostbus_decoder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, ale, io, rd_n, wr_n;
  logic [7:0]  ad, hi;
  logic [39:0] devd;
  logic        mrd, mwr, ird, iwr, err, oe;
  logic [15:0] addr;
  logic [2:0]  mcs;
  logic [1:0]  pcs;
  logic [7:0]  dout;

  hostbus_decoder uut (
    .clk(clk), .rst(rst), .ale_i(ale), .ad_i(ad), .addr_hi_i(hi), .io_sel_i(io),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .dev_rdata_i(devd),
    .mem_rd_o(mrd), .mem_wr_o(mwr), .io_rd_o(ird), .io_wr_o(iwr),
    .strobe_err_o(err), .addr_o(addr), .mem_cs_o(mcs), .port_cs_o(pcs),
    .bus_oe_o(oe), .bus_dout_o(dout)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic        err;
    logic [15:0] addr;
    logic [2:0]  mcs;
    logic [1:0]  pcs;
    logic        oe;
    logic [7:0]  dout;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  logic [7:0] lo_m = 8'h00;

  // driver: applies one bus cycle and queues the expected registered result
  task automatic step(input logic a, input logic [7:0] d, input logic [7:0] h,
                      input logic s, input logic r, input logic w, input string tag);
    exp_t e;
    logic [15:0] fa;
    logic rq, wq, both;
    @(negedge clk);
    ale = a; ad = d; hi = h; io = s; rd_n = r; wr_n = w;
    if (a) lo_m = d;
    fa   = {h, lo_m};
    rq   = !r; wq = !w; both = rq && wq;
    e.cmd = both ? 4'b0 : {rq && !s, wq && !s, rq && s, wq && s};
    e.err = both;
    e.addr = fa;
    e.mcs[0] = !s && (fa <= 16'h3FFF);
    e.mcs[1] = !s && (fa >= 16'h8000) && (fa <= 16'h87FF);
    e.mcs[2] = !s && (fa >= 16'hF000);
    e.pcs[0] = s && (lo_m >= 8'h20) && (lo_m <= 8'h23);
    e.pcs[1] = s && (lo_m >= 8'h80) && (lo_m <= 8'h8F);
    e.oe = (e.cmd[3] || e.cmd[1]) && ((e.mcs != 0) || (e.pcs != 0));
    e.dout = 8'h00;
    if (e.oe) begin
      if (e.mcs[0]) e.dout = devd[7:0];
      if (e.mcs[1]) e.dout = devd[15:8];
      if (e.mcs[2]) e.dout = devd[23:16];
      if (e.pcs[0]) e.dout = devd[31:24];
      if (e.pcs[1]) e.dout = devd[39:32];
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares after each rising edge, away from it
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({mrd, mwr, ird, iwr} !== e.cmd || err !== e.err || addr !== e.addr ||
          mcs !== e.mcs || pcs !== e.pcs || oe !== e.oe || dout !== e.dout) begin
        fails++;
        $display("FAIL %s: got cmd=%b err=%b addr=%h mcs=%b pcs=%b oe=%b dout=%h exp cmd=%b err=%b addr=%h mcs=%b pcs=%b oe=%b dout=%h",
                 e.tag, {mrd, mwr, ird, iwr}, err, addr, mcs, pcs, oe, dout,
                 e.cmd, e.err, e.addr, e.mcs, e.pcs, e.oe, e.dout);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; ale = 1'b0; ad = 8'h00; hi = 8'h00; io = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    devd = {8'hE5, 8'hD4, 8'hC3, 8'hB2, 8'hA1};
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if ({mrd, mwr, ird, iwr, err, oe} !== 6'b0 || addr !== 16'h0 || mcs !== 3'b0 ||
        pcs !== 2'b0 || dout !== 8'h0) begin
      fails++;
      $display("FAIL R1: got cmd=%b err=%b oe=%b addr=%h mcs=%b pcs=%b dout=%h exp all zero",
               {mrd, mwr, ird, iwr}, err, oe, addr, mcs, pcs, dout);
    end
    rst = 1'b0;

    // R2: capture, hold, live high byte
    step(1, 8'h34, 8'h12, 0, 1, 1, "R2 capture");
    step(0, 8'hFF, 8'h12, 0, 1, 1, "R2 hold");
    step(0, 8'h00, 8'h9A, 0, 1, 1, "R2 new high byte");
    // R3: memory commands
    step(1, 8'h10, 8'h00, 0, 0, 1, "R3 mem read region0");
    step(1, 8'h05, 8'h80, 0, 1, 0, "R3 mem write region1");
    step(1, 8'h00, 8'hF8, 0, 0, 1, "R3 mem read region2");
    // R4 / R7: io commands, high byte ignored for ports
    step(1, 8'h21, 8'h55, 1, 0, 1, "R4 io read port0");
    step(1, 8'h8F, 8'hC0, 1, 1, 0, "R4 io write port1");
    step(1, 8'h10, 8'h00, 1, 0, 1, "R7 io space hides memory select");
    // R5: strobe clash and recovery
    step(1, 8'h10, 8'h00, 0, 0, 0, "R5 both strobes mem");
    step(0, 8'hAA, 8'h00, 1, 0, 0, "R5 both strobes io");
    step(0, 8'hAA, 8'h00, 1, 1, 1, "R5 error clears");
    // R6: region boundaries
    step(1, 8'hFF, 8'h3F, 0, 0, 1, "R6 3FFF in");
    step(1, 8'h00, 8'h40, 0, 0, 1, "R6 4000 gap");
    step(1, 8'hFF, 8'h7F, 0, 0, 1, "R6 7FFF gap");
    step(1, 8'h00, 8'h80, 0, 0, 1, "R6 8000 in");
    step(1, 8'hFF, 8'h87, 0, 0, 1, "R6 87FF in");
    step(1, 8'h00, 8'h88, 0, 0, 1, "R6 8800 gap");
    step(1, 8'hFF, 8'hEF, 0, 0, 1, "R6 EFFF gap");
    step(1, 8'hFF, 8'hFF, 0, 0, 1, "R6 FFFF in");
    // R7: port boundaries
    step(1, 8'h1F, 8'h00, 1, 0, 1, "R7 port 1F out");
    step(1, 8'h20, 8'h77, 1, 0, 1, "R7 port 20 in");
    step(1, 8'h23, 8'hFF, 1, 0, 1, "R7 port 23 in");
    step(1, 8'h24, 8'h00, 1, 0, 1, "R7 port 24 out");
    step(1, 8'h80, 8'h33, 1, 0, 1, "R7 port 80 in");
    step(1, 8'h90, 8'h00, 1, 0, 1, "R7 port 90 out");
    // R8: gap read gives command but no select; R9 new device data
    devd = {8'h5E, 8'h4D, 8'h3C, 8'h2B, 8'h1A};
    step(1, 8'h00, 8'h50, 0, 0, 1, "R8 gap read");
    step(1, 8'h22, 8'h00, 1, 0, 1, "R9 port0 new data");
    step(1, 8'h22, 8'h00, 1, 1, 0, "R9 write does not drive");
    step(0, 8'h99, 8'h01, 0, 0, 1, "R9 read with held low byte");
    // R8/R9 sweep over the whole space
    for (int k = 0; k < 64; k++) begin
      logic [15:0] a;
      a = 16'(k * 16'h0409);
      step(1, a[7:0], a[15:8], 0, 0, 1, "R8 memory sweep");
    end
    for (int k = 0; k < 32; k++) begin
      logic [7:0] p;
      p = 8'(k * 8);
      step(1, p, 8'(k), 1, (k % 2 == 0), (k % 2 != 0), "R8 port sweep");
    end
    step(0, 8'h00, 8'h00, 0, 1, 1, "R2 idle");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule